// File: doc/BRIEF.md
# Serial EEPROM Program/Erase Engine

This block is the write controller that sits behind the serial command decoder of a 512-word by 16-bit non-volatile memory. The decoder hands it one decoded command at a time while chip select is high. The engine holds that command and commits it on the clock edge that first samples chip select low. It keeps a volatile write-enable latch. It runs single-word writes, single-word erases, whole-array fills and whole-array erases over a self-timed busy window counted in system clocks. The array changes when the window ends.

After a program operation starts, raising chip select turns the serial data output into a status line: low while the operation runs, high once it has finished. A start bit seen while the status shows ready returns the output to high impedance. A power-good input models loss of supply. While it is low, the latch is cleared, any held command is discarded and an operation in progress is abandoned. A read port exposes the array contents to the read path and to the bench.

Top module: `eep_prog_engine`

## Requirements
- R1: After reset the write-enable latch is clear and `so_oe` is 0.
- R2: `cmd_op` is decoded as 0 = disable writes, 1 = enable writes, 2 = word write, 3 = word erase, 4 = fill all words, 5 = erase all words; other codes are ignored. Enable and disable set and clear the latch. Codes 2 to 5 start only when the latch is set; otherwise they are dropped, leave the array unchanged and start no busy window.
- R3: A word write stores `cmd_data` at `cmd_addr` without a prior erase and leaves every other word unchanged.
- R4: A word erase sets the addressed word to all ones and leaves other words unchanged.
- R5: A fill stores `cmd_data` in every word, whatever value `cmd_addr` holds.
- R6: An erase-all sets every word to all ones.
- R7: The busy window starts on the clock edge that samples `cs` low after it was high with a command held. It lasts exactly BUSY_CYCLES clock cycles. The array keeps its old contents until the window ends.
- R8: During the busy window `cmd_valid`, `start_seen` and further chip-select falls are ignored. A disable command sent then does not clear the latch.
- R9: Once a program operation has started, `so_oe` is 1 whenever `cs` is high and `so` is 0 while busy and 1 when done. If no program operation has started, `so_oe` stays 0 when `cs` rises.
- R10: A `start_seen` pulse while `cs` is high and the status shows ready makes `so_oe` 0 from the next clock edge.
- R11: While `pwr_good` is low the latch clears, a held command is discarded and a running operation is abandoned with the array unchanged. After that, `so_oe` stays 0.
- R12: Only the last command received before `cs` falls is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication, low forces the disabled state |
| cs | input | 1 | Chip select level, synchronous to clk |
| start_seen | input | 1 | One-cycle pulse: decoder sampled a start bit |
| cmd_valid | input | 1 | One-cycle pulse: decoded command present |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | DATA_W | Data word of the command |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data |
| so | output | 1 | Status output value |
| so_oe | output | 1 | Status output enable, 0 means high impedance |

## Verification
The hardest situations to reach are the ones that happen inside the busy window. One is a start bit or a disable command arriving while the engine is busy. The other is supply loss midway through an operation. The bench keeps chip select high for verify right after a commit. It pulses the start and command inputs while the status still reads low, and only later proves that the latch survived by completing another write. For supply loss, it drops power-good for a single cycle partway through the window. It then shows that the status line stays quiet, that the target word keeps its old value, and that the next write is dropped.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      OP_LOCK   = 3'd0,
      OP_UNLOCK = 3'd1,
      OP_WORD   = 3'd2,
      OP_CLEAR  = 3'd3,
      OP_FILL   = 3'd4,
      OP_WIPE   = 3'd5
   } eep_op_e;

   function automatic logic is_program(eep_op_e op);
      return (op == OP_WORD) || (op == OP_CLEAR) || (op == OP_FILL) || (op == OP_WIPE);
   endfunction
endpackage

// File: rtl/eep_cmd_gate.sv
module eep_cmd_gate
   import eep_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              cs,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              busy,
   output logic              launch,
   output eep_op_e           job_op,
   output logic [ADDR_W-1:0] job_addr,
   output logic [DATA_W-1:0] job_data,
   output logic              wel
);
   logic              cs_q;
   logic              pend_vld;
   eep_op_e           pend_op;
   logic [ADDR_W-1:0] pend_addr;
   logic [DATA_W-1:0] pend_data;
   logic              cs_fall;
   logic              op_known;

   assign cs_fall  = cs_q & ~cs;
   assign op_known = (cmd_op <= 3'd5);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q      <= 1'b0;
         pend_vld  <= 1'b0;
         pend_op   <= OP_LOCK;
         pend_addr <= '0;
         pend_data <= '0;
         wel       <= 1'b0;
      end else begin
         cs_q <= cs;
         if (!pwr_good) begin
            pend_vld <= 1'b0;
            wel      <= 1'b0;
         end else if (!busy) begin
            if (cs_fall) begin
               pend_vld <= 1'b0;
               if (pend_vld && pend_op == OP_UNLOCK) wel <= 1'b1;
               if (pend_vld && pend_op == OP_LOCK)   wel <= 1'b0;
            end else if (cs && cmd_valid && op_known) begin
               pend_vld  <= 1'b1;
               pend_op   <= eep_op_e'(cmd_op);
               pend_addr <= cmd_addr;
               pend_data <= cmd_data;
            end
         end
      end
   end

   assign launch   = pwr_good & ~busy & cs_fall & pend_vld & wel & is_program(pend_op);
   assign job_op   = pend_op;
   assign job_addr = pend_addr;
   assign job_data = pend_data;

   // R8: nothing in the command holding stage moves while an operation runs
   a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pwr_good) |=> ($stable(pend_vld) && $stable(pend_addr) && $stable(wel)));
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
   parameter int BUSY_CYCLES = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic launch,
   output logic busy,
   output logic done
);
   localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!pwr_good) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (launch) begin
         busy <= 1'b1;
         cnt  <= LAST;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy & (cnt == '0);

   // R7: the completion pulse ends the window on the following edge
   a_r7_done_ends_window: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !launch) |=> !busy);
endmodule

// File: rtl/eep_array.sv
module eep_array
   import eep_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 16,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  eep_op_e           job_op,
   input  logic [ADDR_W-1:0] job_addr,
   input  logic [DATA_W-1:0] job_data,
   input  logic              commit,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   eep_op_e           run_op;
   logic [ADDR_W-1:0] run_addr;
   logic [DATA_W-1:0] run_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_op   <= OP_LOCK;
         run_addr <= '0;
         run_data <= '0;
      end else if (launch) begin
         run_op   <= job_op;
         run_addr <= job_addr;
         run_data <= job_data;
      end
   end

   always_ff @(posedge clk) begin
      if (commit) begin
         case (run_op)
            OP_WORD:  mem[run_addr] <= run_data;
            OP_CLEAR: mem[run_addr] <= '1;
            OP_FILL:  for (int i = 0; i < DEPTH; i++) mem[i] <= run_data;
            OP_WIPE:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            default:  ;
         endcase
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= mem[rd_addr];
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/eep_prog_engine.sv
module eep_prog_engine
   import eep_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16,
   parameter int BUSY_CYCLES = 2_500_000,
   parameter bit READ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_good,
   input  logic              cs,
   input  logic              start_seen,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              so,
   output logic              so_oe
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 12 && DATA_W >= 1 && BUSY_CYCLES >= 1)
         else $error("eep_prog_engine: parameter out of range");
   end

   logic              launch, busy, done, wel, armed;
   eep_op_e           job_op;
   logic [ADDR_W-1:0] job_addr;
   logic [DATA_W-1:0] job_data;

   eep_cmd_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .busy(busy), .launch(launch), .job_op(job_op), .job_addr(job_addr),
      .job_data(job_data), .wel(wel)
   );

   eep_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .launch(launch),
      .busy(busy), .done(done)
   );

   eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_REG(READ_REG)) u_array (
      .clk(clk), .rst_n(rst_n), .launch(launch), .job_op(job_op), .job_addr(job_addr),
      .job_data(job_data), .commit(done), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // verify status: armed by a launch, dropped by a start bit once ready
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            armed <= 1'b0;
      else if (!pwr_good)                    armed <= 1'b0;
      else if (launch)                       armed <= 1'b1;
      else if (cs && start_seen && !busy)    armed <= 1'b0;
   end

   assign so_oe = armed & cs;
   assign so    = armed & cs & ~busy;

   // R7: a window opens only after chip select was seen falling
   a_r7_open_on_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cs, 2) && !$past(cs)));
   // R2: a window opens only with the enable latch set
   a_r2_latch_gates: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel));
   // R10: a start bit while ready releases the status line
   a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && cs && start_seen && !busy) |=> !so_oe);
   // R11: supply loss clears latch, window and status
   a_r11_supply_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (!busy && !wel && !so_oe));
endmodule

// File: tb/eep_prog_engine_test.sv
module eep_prog_engine_test;
   localparam int AW = 9;
   localparam int DW = 16;
   localparam int BUSY = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b1;
   logic cs = 1'b0;
   logic start_seen = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic so, so_oe;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   eep_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY), .READ_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs), .start_seen(start_seen),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .so(so), .so_oe(so_oe)
   );

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         tag;
   } item_t;

   item_t q[$];
   item_t cur;
   bit    pend = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: owns rd_addr, compares one cycle after issuing it
   initial begin
      forever begin
         @(negedge clk);
         if (pend) begin
            chk(rd_data === cur.d, cur.tag, int'(rd_data), int'(cur.d));
            pend = 1'b0;
         end
         if (q.size() > 0) begin
            cur = q.pop_front();
            rd_addr = cur.a;
            pend = 1'b1;
         end
      end
   end

   task automatic expect_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      item_t it;
      it.a = a; it.d = d; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic drain();
      do begin
         @(negedge clk); #1;
      end while (q.size() != 0 || pend);
   endtask

   // start bit, command, chip select fall; returns one negedge after the fall
   task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk); cs = 1'b1;
      @(negedge clk); start_seen = 1'b1;
      @(negedge clk); start_seen = 1'b0;
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk); cmd_valid = 1'b0;
      @(negedge clk); cs = 1'b0;
      @(negedge clk);
   endtask

   // raises cs and counts cycles of busy status; leaves cs high
   task automatic wait_ready(output int n);
      n = 0;
      cs = 1'b1; #1;
      while (so_oe && !so && n < 10000) begin
         n++;
         @(negedge clk); #1;
      end
   endtask

   task automatic cs_low();
      @(negedge clk); cs = 1'b0;
      @(negedge clk);
   endtask

   int n;

   initial begin
      repeat (3) @(negedge clk);
      #1; chk(so_oe === 1'b0, "R1 reset so_oe", int'(so_oe), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); cs = 1'b1; #1;
      chk(so_oe === 1'b0, "R9 no program -> hi-z", int'(so_oe), 0);
      @(negedge clk); cs = 1'b0;

      // R2: write with latch clear is dropped
      send(3'd2, 9'd5, 16'h1234);
      cs = 1'b1; #1;
      chk(so_oe === 1'b0, "R2 dropped write, no status", int'(so_oe), 0);
      cs_low();

      // R2: enable is not a program operation
      send(3'd1, 9'd0, 16'h0);
      cs = 1'b1; #1;
      chk(so_oe === 1'b0, "R2 enable leaves status off", int'(so_oe), 0);
      cs_low();

      // R6 / R7: erase all, exact busy length
      send(3'd5, 9'd77, 16'h0);
      wait_ready(n);
      chk(n == BUSY, "R7 busy length", n, BUSY);
      chk(so_oe === 1'b1 && so === 1'b1, "R9 ready status", int'({so_oe, so}), 3);
      cs_low();
      expect_word(9'd0, 16'hFFFF, "R6 word 0");
      expect_word(9'd5, 16'hFFFF, "R6 word 5");
      expect_word(9'd511, 16'hFFFF, "R6 word 511");
      expect_word(9'd300, 16'hFFFF, "R6 word 300");
      drain();

      // R3: word write without erase
      send(3'd2, 9'd5, 16'hA5C3);
      wait_ready(n);
      cs_low();
      expect_word(9'd5, 16'hA5C3, "R3 target word");
      expect_word(9'd4, 16'hFFFF, "R3 neighbour below");
      expect_word(9'd6, 16'hFFFF, "R3 neighbour above");
      drain();

      // R7: old contents visible until window ends
      send(3'd2, 9'd7, 16'h1111);
      expect_word(9'd7, 16'hFFFF, "R7 old value during busy");
      drain();
      wait_ready(n);
      cs_low();
      expect_word(9'd7, 16'h1111, "R7 new value after busy");
      drain();

      // R4: word erase
      send(3'd3, 9'd5, 16'h0);
      wait_ready(n);
      cs_low();
      expect_word(9'd5, 16'hFFFF, "R4 erased word");
      expect_word(9'd7, 16'h1111, "R4 other word kept");
      drain();

      // R5: fill ignores address
      send(3'd4, 9'd123, 16'h0F0F);
      wait_ready(n);
      cs_low();
      expect_word(9'd0, 16'h0F0F, "R5 word 0");
      expect_word(9'd123, 16'h0F0F, "R5 word 123");
      expect_word(9'd511, 16'h0F0F, "R5 word 511");
      expect_word(9'd7, 16'h0F0F, "R5 word 7");
      drain();

      // R8: start bit and disable command ignored while busy
      send(3'd2, 9'd9, 16'hBEEF);
      cs = 1'b1;
      @(negedge clk); start_seen = 1'b1;
      @(negedge clk); start_seen = 1'b0; #1;
      chk(so_oe === 1'b1 && so === 1'b0, "R8 start bit ignored while busy", int'({so_oe, so}), 2);
      cmd_valid = 1'b1; cmd_op = 3'd0;
      @(negedge clk); cmd_valid = 1'b0; cs = 1'b0;
      @(negedge clk);
      wait_ready(n);
      chk(so_oe === 1'b1 && so === 1'b1, "R8 ready after window", int'({so_oe, so}), 3);
      // R9: status held across a chip select low/high
      @(negedge clk); cs = 1'b0;
      @(negedge clk); cs = 1'b1; #1;
      chk(so_oe === 1'b1 && so === 1'b1, "R9 status persists", int'({so_oe, so}), 3);
      // R10: start bit while ready releases line
      @(negedge clk); start_seen = 1'b1;
      @(negedge clk); start_seen = 1'b0; #1;
      chk(so_oe === 1'b0, "R10 start releases status", int'(so_oe), 0);
      @(negedge clk); cs = 1'b0;
      expect_word(9'd9, 16'hBEEF, "R8 write during-busy target");
      drain();
      // latch survived the ignored disable
      send(3'd2, 9'd10, 16'h1357);
      wait_ready(n);
      chk(n == BUSY, "R8 latch kept, write runs", n, BUSY);
      cs_low();
      expect_word(9'd10, 16'h1357, "R8 second write stored");
      drain();

      // R12: last command before chip select fall wins
      @(negedge clk); cs = 1'b1;
      @(negedge clk); start_seen = 1'b1;
      @(negedge clk); start_seen = 1'b0;
      cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 9'd10; cmd_data = 16'h0;
      @(negedge clk); cmd_op = 3'd2; cmd_addr = 9'd11; cmd_data = 16'h2222;
      @(negedge clk); cmd_valid = 1'b0;
      @(negedge clk); cs = 1'b0;
      @(negedge clk);
      wait_ready(n);
      cs_low();
      expect_word(9'd11, 16'h2222, "R12 last command applied");
      expect_word(9'd10, 16'h1357, "R12 earlier command discarded");
      drain();

      // R2: disable then write is dropped
      send(3'd0, 9'd0, 16'h0);
      cs_low();
      send(3'd2, 9'd12, 16'h5555);
      cs = 1'b1; #1;
      chk(so_oe === 1'b0, "R2 write after disable dropped", int'(so_oe), 0);
      cs_low();
      expect_word(9'd12, 16'h0F0F, "R2 array unchanged");
      drain();

      // R11: supply loss mid-window
      send(3'd1, 9'd0, 16'h0);
      cs_low();
      send(3'd2, 9'd13, 16'hAAAA);
      cs = 1'b1;
      repeat (5) @(negedge clk);
      pwr_good = 1'b0;
      @(negedge clk); pwr_good = 1'b1; #1;
      chk(so_oe === 1'b0, "R11 status off after supply loss", int'(so_oe), 0);
      repeat (BUSY + 5) @(negedge clk);
      #1; chk(so_oe === 1'b0, "R11 no late status", int'(so_oe), 0);
      cs_low();
      expect_word(9'd13, 16'h0F0F, "R11 abandoned word unchanged");
      drain();
      send(3'd2, 9'd14, 16'h0001);
      cs = 1'b1; #1;
      chk(so_oe === 1'b0, "R11 latch cleared, write dropped", int'(so_oe), 0);
      cs_low();
      expect_word(9'd14, 16'h0F0F, "R11 word 14 unchanged");
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule